// File: doc/BRIEF.md
# Boundary-Scan Test Port with Capture-Only Instructions

This block is the serial test port of a synchronous memory. A 16-state controller is stepped by the test clock and steered by the mode-select line. It places one of four shift registers between the serial input and the serial output: a 3-bit instruction register, a single-bit pass-through register, a 32-bit identification word or a boundary register. The boundary register samples the memory's pin ring.

The block can only observe the pins. Two instructions capture the pin ring and also raise a flag that puts the memory's data outputs into high impedance. A third instruction captures the pins and leaves the outputs alone. The Update-DR state never drives or preloads anything. There is no dedicated test reset pin: the port is reset by holding the mode-select line high, or by an active-low power-on reset. Either reset acts on the test logic only.

Top module: `scan_port`

## Requirements
- R1: Five consecutive rising TCK edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R2: While `por_n` is low, the controller is in Test-Logic-Reset, the current instruction is IDCODE, `tdo_en` is 0 and `outputs_hiz` is 0.
- R3: Capture-IR loads 3'b001 into the instruction shift stage, so the first three bits out are 1, 0, 0. Shift-IR moves `tdi` into the MSB and shifts the LSB out first.
- R4: The current instruction changes only on the edge that leaves Update-IR, or when Test-Logic-Reset reloads it. Shifting alone never alters `outputs_hiz`.
- R5: Each rising edge taken in Test-Logic-Reset makes IDCODE (3'b001) the current instruction.
- R6: With IDCODE current, the data path is 32 bits and bit 0 shifts out first. Bit 0 is 1, bits 11:1 hold the vendor field, bits 17:12 are 0, bits 22:18 hold the width field, bits 27:23 hold the depth field and bits 31:28 hold the revision.
- R7: BYPASS (3'b111) and the reserved codes 3'b011, 3'b101 and 3'b110 select a one-bit register that captures 0. `tdo` then repeats `tdi` one shift later.
- R8: EXTEST (3'b000), SAMPLE (3'b100) and SAMPLE-Z (3'b010) select the boundary register, 70 bits by default. Capture-DR loads `pins`, and `pins[0]` shifts out first. The placeholder positions 33 and 36 capture 1 whatever their pin value.
- R9: `outputs_hiz` is 1 exactly while the current instruction is EXTEST or SAMPLE-Z.
- R10: Update-DR has no effect. The instruction and `outputs_hiz` are unchanged, and the next Capture-DR loads the pins rather than the shifted-in data.
- R11: `tms` and `tdi` are sampled on rising TCK. `tdo` and `tdo_en` change on falling TCK, and `tdo_en` is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| pins | input | BSR_LEN | Parallel sample of the memory pin ring; bit 0 leaves first |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for `tdo`; low means high impedance |
| outputs_hiz | output | 1 | Forces the memory data outputs to high impedance |

## Verification
The assertions check several rules on every cycle. Five edges of `tms` high always end in reset. The instruction register changes only after Update-IR or in reset. Capture loads the pass-through bit with zero and the boundary register with the sampled pins and placeholder ones. The output enable follows the shift states, and the high-impedance flag never moves across Update-DR. Other behaviour can only be shown by the bench's scenarios against its reference controller: the exact bit streams of the identification word and the boundary register, the one-shift delay through bypass, the reserved codes falling back to bypass, and the proof that Update-DR preloads nothing (a later capture returning the pins).

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYP,
        SEL_ID,
        SEL_BSR
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_TLR:    r_d.st = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    r_d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: r_d.st = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  r_d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: r_d.st = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: r_d.st = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: r_d.st = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: r_d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: r_d.st = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  r_d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: r_d.st = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: r_d.st = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: r_d.st = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: r_d.st = tms ? ST_SEL_DR : ST_RTI;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) r_q <= '{st: ST_TLR};
        else        r_q <= r_d;
    end

    assign state = r_q.st;

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (r_q.st == ST_TLR)); // R1

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_cur,
    output logic            ir_lsb
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] cur;
    } ir_t;

    ir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_CAP_IR: r_d.sh  = IR_W'(2'b01);
            ST_SH_IR:  r_d.sh  = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.cur = r_q.sh;
            ST_TLR:    r_d.cur = OP_IDCODE;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) r_q <= '{sh: '0, cur: OP_IDCODE};
        else        r_q <= r_d;
    end

    assign ir_cur = r_q.cur;
    assign ir_lsb = r_q.sh[0];

    AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state) == ST_CAP_IR) |-> (r_q.sh == IR_W'(2'b01))); // R3

    AST_IR_CHANGES_ON_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(r_q.cur) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR)); // R4

endmodule

// File: rtl/scan_dr.sv
module scan_dr
    import scan_pkg::*;
#(
    parameter int                 BSR_LEN  = 70,
    parameter logic [BSR_LEN-1:0] ONE_MASK = 70'h12_0000_0000,
    parameter logic [ID_W-1:0]    ID_WORD  = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               por_n,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins,
    output logic               dr_lsb
);

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] bsr;
    } dr_t;

    dr_t                r_d, r_q;
    logic [BSR_LEN-1:0] cap_vec;

    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cap
        if (ONE_MASK[i]) begin : g_hold
            assign cap_vec[i] = 1'b1;
        end else begin : g_pin
            assign cap_vec[i] = pins[i];
        end
    end

    always_comb begin
        r_d = r_q;
        if (state == ST_CAP_DR) begin
            case (sel)
                SEL_ID:  r_d.id  = ID_WORD;
                SEL_BSR: r_d.bsr = cap_vec;
                default: r_d.byp = 1'b0;
            endcase
        end else if (state == ST_SH_DR) begin
            case (sel)
                SEL_ID:  r_d.id  = {tdi, r_q.id[ID_W-1:1]};
                SEL_BSR: r_d.bsr = {tdi, r_q.bsr[BSR_LEN-1:1]};
                default: r_d.byp = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_lsb = r_q.id[0];
            SEL_BSR: dr_lsb = r_q.bsr[0];
            default: dr_lsb = r_q.byp;
        endcase
    end

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state) == ST_CAP_DR && $past(sel) == SEL_BYP) |-> !r_q.byp); // R7

    AST_BSR_CAPTURES_PINS: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state) == ST_CAP_DR && $past(sel) == SEL_BSR)
        |-> (r_q.bsr == ($past(pins) | ONE_MASK))); // R8

endmodule

// File: rtl/scan_port.sv
module scan_port
    import scan_pkg::*;
#(
    parameter int                 BSR_LEN   = 70,
    parameter logic [BSR_LEN-1:0] ONE_MASK  = 70'h12_0000_0000,
    parameter logic [10:0]        ID_VENDOR = 11'h00E,
    parameter logic [4:0]         ID_WIDTH  = 5'b00100,
    parameter logic [4:0]         ID_DEPTH  = 5'b00101,
    parameter logic [3:0]         ID_REV    = 4'h0
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins,
    output logic               tdo,
    output logic               tdo_en,
    output logic               outputs_hiz
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_DEPTH, ID_WIDTH, 6'b0, ID_VENDOR, 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] ir_cur;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_sel_e         sel;

    typedef struct packed {
        logic bit_out;
        logic en;
    } out_t;

    out_t o_d, o_q;

    scan_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    scan_ir u_ir (
        .tck    (tck),
        .por_n  (por_n),
        .state  (state),
        .tdi    (tdi),
        .ir_cur (ir_cur),
        .ir_lsb (ir_lsb)
    );

    scan_dr #(
        .BSR_LEN  (BSR_LEN),
        .ONE_MASK (ONE_MASK),
        .ID_WORD  (ID_WORD)
    ) u_dr (
        .tck    (tck),
        .por_n  (por_n),
        .state  (state),
        .sel    (sel),
        .tdi    (tdi),
        .pins   (pins),
        .dr_lsb (dr_lsb)
    );

    always_comb begin
        case (ir_cur)
            OP_EXTEST, OP_SAMPLE, OP_SAMPZ: sel = SEL_BSR;
            OP_IDCODE:                      sel = SEL_ID;
            default:                        sel = SEL_BYP;
        endcase
        outputs_hiz = (ir_cur == OP_EXTEST) || (ir_cur == OP_SAMPZ);
    end

    always_comb begin
        o_d.en      = (state == ST_SH_DR) || (state == ST_SH_IR);
        o_d.bit_out = 1'b0;
        if (state == ST_SH_IR)      o_d.bit_out = ir_lsb;
        else if (state == ST_SH_DR) o_d.bit_out = dr_lsb;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign tdo    = o_q.bit_out;
    assign tdo_en = o_q.en;

    AST_HIZ_RISES_AFTER_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
        $rose(outputs_hiz) |-> ($past(state) == ST_UPD_IR)); // R9

    AST_UPDATE_DR_INERT: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_UPD_DR) |=> $stable(outputs_hiz)); // R10

    AST_TDO_EN_IN_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR)); // R11

endmodule

// File: tb/scan_port_tb.sv
module scan_port_tb;

    localparam int N = 70;
    localparam logic [N-1:0] MASK = (70'd1 << 33) | (70'd1 << 36);
    localparam logic [31:0] EXP_ID = 32'd1 | (32'h00E << 1) | (32'd4 << 18) | (32'd5 << 23);

    logic         tck = 1'b0;
    logic         por_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b1;
    logic [N-1:0] pins = '0;
    wire          tdo, tdo_en, outputs_hiz;

    int total = 0;
    int bad = 0;
    bit done = 0;

    scan_port u_dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pins(pins),
        .tdo(tdo), .tdo_en(tdo_en), .outputs_hiz(outputs_hiz)
    );

    always #10 tck = ~tck;

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference controller ----------------
    int        ms;
    int        mir;
    bit        irq[$];
    bit        drq[$];

    function automatic int nxt(input int s, input bit m);
        case (s)
            0: return m ? 0 : 1;    1: return m ? 2 : 1;
            2: return m ? 9 : 3;    3: return m ? 5 : 4;
            4: return m ? 5 : 4;    5: return m ? 8 : 6;
            6: return m ? 7 : 6;    7: return m ? 8 : 4;
            8: return m ? 2 : 1;    9: return m ? 0 : 10;
            10: return m ? 12 : 11; 11: return m ? 12 : 11;
            12: return m ? 15 : 13; 13: return m ? 14 : 13;
            14: return m ? 15 : 11; default: return m ? 2 : 1;
        endcase
    endfunction

    always @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ms = 0; mir = 1;
        end else begin
            case (ms)
                0: mir = 1;
                3: begin
                    drq.delete();
                    if (mir == 0 || mir == 2 || mir == 4) begin
                        for (int i = 0; i < N; i++) drq.push_back(pins[i] | MASK[i]);
                    end else if (mir == 1) begin
                        for (int i = 0; i < 32; i++) drq.push_back(EXP_ID[i]);
                    end else drq.push_back(1'b0);
                end
                4: begin drq.push_back(tdi); void'(drq.pop_front()); end
                10: begin irq.delete(); irq.push_back(1); irq.push_back(0); irq.push_back(0); end
                11: begin irq.push_back(tdi); void'(irq.pop_front()); end
                15: mir = irq[0] + 2 * irq[1] + 4 * irq[2];
                default: ;
            endcase
            ms = nxt(ms, tms);
        end
    end

    always @(negedge tck) begin
        #2;
        if (por_n && !done) begin
            chk(tdo_en == (ms == 4 || ms == 11), "R11 tdo_en", N'(tdo_en), N'(ms == 4 || ms == 11));
            chk(outputs_hiz == (mir == 0 || mir == 2), "R9 outputs_hiz", N'(outputs_hiz), N'(mir == 0 || mir == 2));
            if (ms == 11)
                chk(tdo == irq[0], "R3 tdo ir", N'(tdo), N'(irq[0]));
            if (ms == 4)
                chk(tdo == drq[0], (mir == 1) ? "R6 tdo id" : ((mir == 0 || mir == 2 || mir == 4) ? "R8 tdo bsr" : "R7 tdo byp"),
                    N'(tdo), N'(drq[0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input bit m, input bit d, output bit o);
        o = tdo;
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output bit hiz_pre);
        bit o;
        step(1, 1, o); step(1, 1, o); step(0, 1, o); step(0, 1, o);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o);
            cap[i] = o;
        end
        hiz_pre = outputs_hiz;
        step(1, 1, o); step(0, 1, o);
    endtask

    task automatic shift_dr(input int n, input logic [N-1:0] din, output logic [N-1:0] dout);
        bit o;
        dout = '0;
        step(1, 1, o); step(0, 1, o); step(0, 1, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1, 1, o); step(0, 1, o);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] dout;
        logic [N-1:0] pat;
        logic [2:0]   cap;
        bit           hp, o;

        // R2: reset state
        repeat (3) @(negedge tck);
        #1;
        chk(tdo_en == 0, "R2 tdo_en in reset", N'(tdo_en), 0);
        chk(outputs_hiz == 0, "R2 hiz in reset", N'(outputs_hiz), 0);
        por_n = 1;
        step(0, 1, o);

        // R5/R6: IDCODE is current after reset
        shift_dr(32, N'(32'hFFFF_FFFF), dout);
        chk(dout[31:0] == EXP_ID, "R6 id word", dout, N'(EXP_ID));

        // R3/R4/R9: load EXTEST, hiz only after Update-IR
        load_ir(3'b000, cap, hp);
        chk(cap == 3'b001, "R3 captured ir", N'(cap), N'(3'b001));
        chk(hp == 0, "R4 hiz before update", N'(hp), 0);
        chk(outputs_hiz == 1, "R9 extest hiz", N'(outputs_hiz), 1);

        // R8: boundary capture under EXTEST
        pins = 70'h2A_5A5A_F00F_1234_ABCD;
        shift_dr(N, '0, dout);
        chk(dout == (pins | MASK), "R8 bsr extest", dout, pins | MASK);

        // R10: SAMPLE then Update-DR has no preload effect
        load_ir(3'b100, cap, hp);
        chk(hp == 1, "R4 hiz held until update", N'(hp), 1);
        chk(outputs_hiz == 0, "R9 sample no hiz", N'(outputs_hiz), 0);
        pins = 70'h15_0F0F_3C3C_8765_4321;
        pat  = 70'h3F_FFFF_0000_FFFF_0000;
        shift_dr(N, pat, dout);
        chk(dout == (pins | MASK), "R8 bsr sample", dout, pins | MASK);
        chk(outputs_hiz == 0, "R10 hiz after update-dr", N'(outputs_hiz), 0);
        shift_dr(N, '0, dout);
        chk(dout == (pins | MASK), "R10 no preload", dout, pins | MASK);

        // R9: SAMPLE-Z
        load_ir(3'b010, cap, hp);
        chk(outputs_hiz == 1, "R9 samplez hiz", N'(outputs_hiz), 1);

        // R7: bypass and reserved code
        pat = 70'h0_0000_0000_0000_B5A3;
        load_ir(3'b111, cap, hp);
        shift_dr(16, pat, dout);
        chk(dout[15:0] == {pat[14:0], 1'b0}, "R7 bypass delay", dout, N'({pat[14:0], 1'b0}));
        load_ir(3'b101, cap, hp);
        shift_dr(16, pat, dout);
        chk(dout[15:0] == {pat[14:0], 1'b0}, "R7 reserved code", dout, N'({pat[14:0], 1'b0}));

        // R1/R5: five TMS-high edges from Shift-DR
        load_ir(3'b010, cap, hp);
        step(1, 1, o); step(0, 1, o); step(0, 1, o);
        repeat (5) step(1, 1, o);
        chk(tdo_en == 0, "R1 reached reset", N'(tdo_en), 0);
        step(0, 1, o);
        chk(outputs_hiz == 0, "R5 idcode reloaded", N'(outputs_hiz), 0);
        shift_dr(32, '0, dout);
        chk(dout[31:0] == EXP_ID, "R1 id after tms reset", dout, N'(EXP_ID));

        // R2: power-on reset mid-run
        load_ir(3'b000, cap, hp);
        por_n = 0;
        #25;
        chk(outputs_hiz == 0, "R2 hiz cleared by por", N'(outputs_hiz), 0);
        chk(tdo_en == 0, "R2 tdo_en cleared by por", N'(tdo_en), 0);
        @(negedge tck); #1;
        por_n = 1;
        step(0, 1, o);
        shift_dr(32, '0, dout);
        chk(dout[31:0] == EXP_ID, "R2 id after por", dout, N'(EXP_ID));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule